// File: doc/BRIEF.md
# 1000BASE-X PCS Transmit Path

This block sits between a GMII transmit port and an 8b/10b encoder. Every transmit clock it turns one GMII byte, with its enable and error flags, into one 8-bit code group and a control/data flag. An unused line carries idle ordered-sets, and each of them starts on an even code-group position. A frame is wrapped in start and end delimiters. Carrier extension and in-frame errors map to their special code groups. When the auto-negotiation logic requests it, configuration ordered-sets carrying a 16-bit word are sent in place of idles.

The block does not track running disparity. It raises a correction strobe together with every idle code group, and the downstream encoder uses it to send idles with negative disparity. Outputs are registered, so each code group appears one clock after the GMII inputs it came from were sampled. Code-group positions are counted from the reset value, which is position 0 (even). After that the position alternates odd and even on every clock.

Top module: `gx_pcs_tx`

## Requirements
- R1: During and after reset the output is an idle stream: K28.5 (0xBC, flag 1) on even positions and D16.2 (0x50, flag 0) on odd positions. The reset value itself is K28.5 at position 0.
- R2: Every code group appears on the outputs one clock after the inputs that produced it were sampled.
- R3: A tx_en cycle that falls on an even position while idling is replaced by /S/ (0xFB, flag 1). A tx_en cycle on an odd position finishes the idle with D16.2, and the next tx_en byte becomes /S/.
- R4: While tx_en is high after /S/ and tx_er is low, each GMII byte is passed through as a data code group (flag 0).
- R5: tx_er together with tx_en high inside a frame produces /V/ (0xFE, flag 1) instead of the byte.
- R6: The first cycle with tx_en low after a frame produces /T/ (0xFD, flag 1), and the next produces /R/ (0xF7, flag 1). If that /R/ sits on an even position, one more /R/ follows so that idle resumes on an even position.
- R7: Each cycle after /T/ that has tx_en low, tx_er high and byte 0x0F (carrier extension) adds one /R/ before the closing /R/ of R6.
- R8: While config transmit is requested, the block sends 4-group ordered-sets. Each set is K28.5, then D21.5 (0xB5) for the first set and D2.2 (0x42) for the second set, alternating, then the config word low byte, then its high byte. The word is captured when the set's K28.5 is sent, and the first set after idle always uses D21.5.
- R9: Config sets begin only on an even idle position and take priority over tx_en there. tx_en is ignored during a config set, and a set that has started is always completed.
- R10: The disparity-correction output is 1 exactly when the output is an idle code group (the K28.5 or D16.2 of an idle). It is 0 for every other code group, including the K28.5 of a config set.
- R11: K28.5 and /S/ appear only on even positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz transmit clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gmii_txd | input | 8 | GMII transmit byte |
| gmii_txen | input | 1 | GMII transmit enable |
| gmii_txer | input | 1 | GMII transmit error / extension flag |
| an_cfg_req | input | 1 | Request to send configuration ordered-sets |
| an_cfg_word | input | 16 | Configuration word to advertise |
| cg_byte | output | 8 | Code group byte |
| cg_is_k | output | 1 | 1 = control code group, 0 = data |
| cg_fix_disp | output | 1 | Disparity-correction strobe, high on idle code groups |

## Verification
Frames are swept over every combination of idle gap parity, frame length from one to five bytes, clean or errored content, and zero to two extension cycles. This separates start-delimiter placement on even versus odd positions, the extra alignment /R/, and extension /R/s from the closing /R/. Config requests of one to nine cycles, started at both parities and with tx_en toggling underneath, show whether set completion, C1/C2 alternation, byte order and the priority over tx_en are right. A non-extension tx_er pattern in the gap must leave the idle stream unchanged.

// File: rtl/gx_pcs_tx_pkg.sv
package gx_pcs_tx_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CG_K28_5 = 8'hBC;
    localparam logic [BYTE_W-1:0] CG_D16_2 = 8'h50;
    localparam logic [BYTE_W-1:0] CG_SOP   = 8'hFB;
    localparam logic [BYTE_W-1:0] CG_EOP   = 8'hFD;
    localparam logic [BYTE_W-1:0] CG_CEXT  = 8'hF7;
    localparam logic [BYTE_W-1:0] CG_ERRP  = 8'hFE;
    localparam logic [BYTE_W-1:0] CG_D21_5 = 8'hB5;
    localparam logic [BYTE_W-1:0] CG_D2_2  = 8'h42;
    localparam logic [BYTE_W-1:0] GMII_EXT = 8'h0F;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FRAME,
        PH_TAIL,
        PH_PAD,
        PH_CFG
    } tx_phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              is_k;
        logic              fix_disp;
    } cg_t;
endpackage

// File: rtl/gx_cfg_seq.sv
module gx_cfg_seq
    import gx_pcs_tx_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CFG_W-1:0] word_in,
    output cg_t              grp,
    output logic             last
);
    localparam int LANES   = CFG_W / BYTE_W;
    localparam int SET_LEN = 2 + LANES;
    localparam int IDX_W   = $clog2(SET_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SET_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_BYTE0 = IDX_W'(2);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             alt;
        logic [CFG_W-1:0] word;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic [IDX_W-1:0] lane;

    always_comb begin
        st_d = st_q;
        if (take) begin
            if (st_q.idx == IDX_LAST) begin
                st_d.idx = '0;
                st_d.alt = ~st_q.alt;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
            if (st_q.idx == '0) begin
                st_d.word = word_in;
            end
        end else begin
            st_d.idx = '0;
            st_d.alt = 1'b0;
        end
    end

    always_comb begin
        lane = st_q.idx - IDX_BYTE0;
        grp.fix_disp = 1'b0;
        if (st_q.idx == '0) begin
            grp.data = CG_K28_5;
            grp.is_k = 1'b1;
        end else if (st_q.idx == IDX_W'(1)) begin
            grp.data = st_q.alt ? CG_D2_2 : CG_D21_5;
            grp.is_k = 1'b0;
        end else begin
            grp.data = st_q.word[lane*BYTE_W +: BYTE_W];
            grp.is_k = 1'b0;
        end
        last = (st_q.idx == IDX_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a run of config sets begins with the first variant
    assert_cfg_first_variant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !$past(take)) |-> (!st_q.alt && st_q.idx == '0));

    // R9: once a set has started, it keeps being consumed until its last group
    assert_cfg_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !last) |=> take);
endmodule

// File: rtl/gx_tx_frame_fsm.sv
module gx_tx_frame_fsm
    import gx_pcs_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] txd,
    input  logic              txen,
    input  logic              txer,
    input  logic              cfg_req,
    input  cg_t               cfg_grp,
    input  logic              cfg_last,
    output logic              cfg_take,
    output cg_t               cg_out
);
    typedef struct packed {
        tx_phase_e phase;
        logic      odd;
        cg_t       cg;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    ext;

    function automatic cg_t mk(input logic [BYTE_W-1:0] b, input logic k, input logic f);
        cg_t r;
        r.data     = b;
        r.is_k     = k;
        r.fix_disp = f;
        return r;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.odd = ~st_q.odd;
        cfg_take = 1'b0;
        ext      = !txen && txer && (txd == GMII_EXT);
        unique case (st_q.phase)
            PH_IDLE: begin
                if (st_q.odd) begin
                    st_d.cg = mk(CG_D16_2, 1'b0, 1'b1);
                end else if (cfg_req) begin
                    st_d.cg    = cfg_grp;
                    cfg_take   = 1'b1;
                    st_d.phase = PH_CFG;
                end else if (txen) begin
                    st_d.cg    = mk(CG_SOP, 1'b1, 1'b0);
                    st_d.phase = PH_FRAME;
                end else begin
                    st_d.cg = mk(CG_K28_5, 1'b1, 1'b1);
                end
            end
            PH_FRAME: begin
                if (txen) begin
                    st_d.cg = txer ? mk(CG_ERRP, 1'b1, 1'b0) : mk(txd, 1'b0, 1'b0);
                end else begin
                    st_d.cg    = mk(CG_EOP, 1'b1, 1'b0);
                    st_d.phase = PH_TAIL;
                end
            end
            PH_TAIL: begin
                st_d.cg = mk(CG_CEXT, 1'b1, 1'b0);
                if (!ext) begin
                    st_d.phase = st_q.odd ? PH_IDLE : PH_PAD;
                end
            end
            PH_PAD: begin
                st_d.cg    = mk(CG_CEXT, 1'b1, 1'b0);
                st_d.phase = PH_IDLE;
            end
            PH_CFG: begin
                st_d.cg  = cfg_grp;
                cfg_take = 1'b1;
                if (cfg_last && !cfg_req) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: begin
                st_d.cg    = mk(CG_K28_5, 1'b1, 1'b1);
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.odd   <= 1'b1;
            st_q.cg    <= mk(CG_K28_5, 1'b1, 1'b1);
        end else begin
            st_q <= st_d;
        end
    end

    assign cg_out = st_q.cg;

    // R11: commas and start delimiters leave on even positions only
    assert_comma_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_out.is_k && (cg_out.data == CG_K28_5 || cg_out.data == CG_SOP)) |-> st_q.odd);

    // R6: an end delimiter is always followed by a carrier-extend group
    assert_eop_then_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_out.is_k && cg_out.data == CG_EOP) |=> (cg_out.is_k && cg_out.data == CG_CEXT));

    // R10: the correction strobe accompanies idle code groups only
    assert_fix_idle_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cg_out.fix_disp |-> ((cg_out.is_k && cg_out.data == CG_K28_5) ||
                             (!cg_out.is_k && cg_out.data == CG_D16_2)));

    // R3: a start delimiter needs tx_en on the sampled cycle
    assert_sop_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_out.is_k && cg_out.data == CG_SOP) |-> $past(txen));
endmodule

// File: rtl/gx_pcs_tx.sv
module gx_pcs_tx
    import gx_pcs_tx_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] gmii_txd,
    input  logic              gmii_txen,
    input  logic              gmii_txer,
    input  logic              an_cfg_req,
    input  logic [CFG_W-1:0]  an_cfg_word,
    output logic [BYTE_W-1:0] cg_byte,
    output logic              cg_is_k,
    output logic              cg_fix_disp
);
    cg_t  cfg_grp;
    cg_t  cg_out;
    logic cfg_last;
    logic cfg_take;

    gx_cfg_seq #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (cfg_take),
        .word_in (an_cfg_word),
        .grp     (cfg_grp),
        .last    (cfg_last)
    );

    gx_tx_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .txd      (gmii_txd),
        .txen     (gmii_txen),
        .txer     (gmii_txer),
        .cfg_req  (an_cfg_req),
        .cfg_grp  (cfg_grp),
        .cfg_last (cfg_last),
        .cfg_take (cfg_take),
        .cg_out   (cg_out)
    );

    assign cg_byte     = cg_out.data;
    assign cg_is_k     = cg_out.is_k;
    assign cg_fix_disp = cg_out.fix_disp;
endmodule

// File: tb/gx_pcs_tx_test.sv
module gx_pcs_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  txd = 8'h00;
    logic        txen = 1'b0;
    logic        txer = 1'b0;
    logic        cfg_req = 1'b0;
    logic [15:0] cfg_word = 16'h0000;
    logic [7:0]  cg_byte;
    logic        cg_is_k;
    logic        cg_fix_disp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side expectation state
    int          m_ph;
    bit          m_odd;
    int          m_idx;
    bit          m_alt;
    logic [15:0] m_word;
    int          pos_cnt;
    logic [7:0]  e_d;
    logic        e_k;
    logic        e_f;
    string       e_tag;

    always #10 clk = ~clk;

    gx_pcs_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .gmii_txd    (txd),
        .gmii_txen   (txen),
        .gmii_txer   (txer),
        .an_cfg_req  (cfg_req),
        .an_cfg_word (cfg_word),
        .cg_byte     (cg_byte),
        .cg_is_k     (cg_is_k),
        .cg_fix_disp (cg_fix_disp)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at pos %0d: actual %h expected %h", tag, pos_cnt, act, exp);
        end
    endtask

    task automatic expect_cg(input logic [7:0] d, input logic k, input logic f, input string tag);
        e_d = d; e_k = k; e_f = f; e_tag = tag;
    endtask

    task automatic cfg_group(input logic [15:0] w, input bit en_now);
        string t;
        t = en_now ? "R8 R9" : "R8";
        case (m_idx)
            0: begin expect_cg(8'hBC, 1'b1, 1'b0, t); m_word = w; end
            1: expect_cg(m_alt ? 8'h42 : 8'hB5, 1'b0, 1'b0, t);
            2: expect_cg(m_word[7:0], 1'b0, 1'b0, t);
            default: expect_cg(m_word[15:8], 1'b0, 1'b0, t);
        endcase
    endtask

    task automatic step(input bit en, input bit er, input logic [7:0] d,
                        input bit cr, input logic [15:0] w);
        bit ext;
        bit last;
        txen = en; txer = er; txd = d; cfg_req = cr; cfg_word = w;
        ext  = !en && er && (d == 8'h0F);
        last = 1'b0;
        case (m_ph)
            0: begin
                if (m_odd) begin
                    expect_cg(8'h50, 1'b0, 1'b1, en ? "R3 R1" : "R1");
                end else if (cr) begin
                    cfg_group(w, en);
                    m_ph = 4;
                end else if (en) begin
                    expect_cg(8'hFB, 1'b1, 1'b0, "R3");
                    m_ph = 1;
                end else begin
                    expect_cg(8'hBC, 1'b1, 1'b1, "R1");
                end
            end
            1: begin
                if (en) begin
                    if (er) expect_cg(8'hFE, 1'b1, 1'b0, "R5");
                    else    expect_cg(d, 1'b0, 1'b0, "R4 R2");
                end else begin
                    expect_cg(8'hFD, 1'b1, 1'b0, "R6");
                    m_ph = 2;
                end
            end
            2: begin
                expect_cg(8'hF7, 1'b1, 1'b0, ext ? "R7" : "R6");
                if (!ext) m_ph = m_odd ? 0 : 3;
            end
            3: begin
                expect_cg(8'hF7, 1'b1, 1'b0, "R6");
                m_ph = 0;
            end
            default: begin
                cfg_group(w, en);
            end
        endcase
        if (m_ph == 4 && e_tag.len() > 0) begin
            if (m_idx == 3) begin
                m_idx = 0; m_alt = !m_alt; last = 1'b1;
            end else begin
                m_idx++;
            end
            if (last && !cr) begin
                m_ph = 0; m_alt = 1'b0;
            end
        end
        m_odd = !m_odd;
        @(posedge clk);
        @(negedge clk);
        pos_cnt++;
        chk({e_tag, " byte"}, cg_byte, e_d);
        chk({e_tag, " flag"}, {7'd0, cg_is_k}, {7'd0, e_k});
        chk("R10 strobe", {7'd0, cg_fix_disp}, {7'd0, e_f});
        if (cg_is_k && (cg_byte == 8'hBC || cg_byte == 8'hFB)) begin
            // R11: position parity counted from the reset value at position 0
            chk("R11 parity", {7'd0, pos_cnt[0]}, 8'd0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0, 16'h0000);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value
        chk("R1 reset byte", cg_byte, 8'hBC);
        chk("R1 reset flag", {7'd0, cg_is_k}, 8'd1);
        chk("R10 reset strobe", {7'd0, cg_fix_disp}, 8'd1);
        m_ph = 0; m_odd = 1'b1; m_idx = 0; m_alt = 1'b0; m_word = '0; pos_cnt = 0;
        rst_n = 1'b1;
        idle(6);

        // frame sweep: gap parity, length, error content, extension length
        for (int g = 0; g < 4; g++) begin
            for (int len = 1; len <= 5; len++) begin
                for (int em = 0; em < 2; em++) begin
                    for (int e = 0; e < 3; e++) begin
                        idle(g);
                        for (int i = 0; i < len; i++) begin
                            step(1'b1, (em == 1) && (i == 1), 8'((g << 6) + (len << 3) + i + 1),
                                 1'b0, 16'h0000);
                        end
                        for (int x = 0; x < e; x++) step(1'b0, 1'b1, 8'h0F, 1'b0, 16'h0000);
                        // error in the gap without the extension byte must not disturb idles
                        step(1'b0, 1'b1, 8'h0E, 1'b0, 16'h0000);
                        idle(4);
                    end
                end
            end
        end

        // config sweep: start parity, request length, tx_en underneath
        for (int g = 0; g < 2; g++) begin
            for (int n = 1; n <= 9; n++) begin
                idle(g + 4);
                for (int i = 0; i < n; i++) begin
                    step(i[0], 1'b0, 8'h55, 1'b1, 16'((n << 12) | 16'h0A3C | (g << 8)));
                end
                idle(8);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule